// File: doc/BRIEF.md
# Timing Error Counter Comparator

This block measures how far a stream of NCO carry-out pulses has drifted against an external reference clock. Two preloadable down counters run side by side. One steps on each NCO carry pulse and the other on each reference tick. Both pulse inputs are single-cycle strobes that are already synchronous to the system clock.

Each time the reference counter completes a period, the block takes the current NCO count and subtracts half of the NCO divide value. The result is a signed phase error that sits at zero when the two event streams are in the nominal ratio. It is sign-extended and kept in a 16-bit error register. A processor can read that register at any time. The same word is offered on a valid/ready output stream for a serial shifter.

Writing a new configuration word loads both divide values and restarts both counters together, so every later comparison starts from a known alignment. An external loop filter may use the error to steer the NCO frequency; that filter is not part of this block.

Top module: `timing_err_cmp`

## Requirements
- R1: After reset, `err_word` is 0 and `err_valid` is 0. The NCO counter starts at `NCO_DIV_RST` (default 100) and the reference counter starts at `REF_DIV_RST` (default 3).
- R2: The NCO counter decrements by one on each `nco_tick`. On a tick while it holds 0, it reloads the NCO divide value instead, so its period is divide+1 ticks.
- R3: The reference counter follows the same rule on `ref_tick` with the reference divide value. A reference tick that arrives while the reference counter holds 0 is a "reference wrap".
- R4: On `cfg_wr`, the NCO divide value is taken from `cfg_word[27:16]` and the reference divide value from `cfg_word[11:0]`. All other bits of `cfg_word` are ignored.
- R5: On a reference wrap, the next cycle shows `err_word` = NCO count minus floor(NCO divide / 2). The difference is signed and sign-extended to 16 bits (two's complement), and `err_valid` is 1 in that cycle.
- R6: When an NCO tick and a reference wrap fall in the same cycle, the captured count is the NCO count from before that tick.
- R7: `cfg_wr` reloads both counters with the new divide values in the same cycle. Any tick in that cycle is ignored, and that cycle produces no capture.
- R8: `err_word` changes only on a capture. Between captures it holds the most recent result.
- R9: Output stream: once `err_valid` is raised, it stays 1 until a cycle with `err_ready` high. Without a new capture, it then drops in the next cycle. A capture while a word is still pending replaces the word; only the newest measurement is kept, and `err_valid` stays 1. The producer is never stalled by back-pressure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | One-cycle strobe: load divide values and restart counters |
| cfg_word | input | 32 | Configuration word carrying both divide fields |
| nco_tick | input | 1 | NCO carry-out pulse, one cycle per event |
| ref_tick | input | 1 | Reference clock event pulse, one cycle per event |
| err_word | output | 16 | Signed timing error, latest measurement |
| err_valid | output | 1 | Stream valid for `err_word` |
| err_ready | input | 1 | Stream ready from the consumer |

## Verification
Two functions can fall in the same cycle: a reference wrap that captures the NCO count, and an NCO tick that changes that count. The bench drives both pulses together on a known count, directed and many times at random. It checks that the error reflects the count from before the tick, and that the next wrap sees the decremented count. A second overlap is a capture landing while the output word is still unaccepted. Here the bench holds `err_ready` low across two captures and judges that the newer word replaces the older one and `err_valid` never drops.

// File: rtl/tec_pkg.sv
package tec_pkg;
  localparam int TEC_DIV_W = 12;
  localparam int TEC_ERR_W = 16;
  localparam int TEC_CFG_W = 32;
  localparam int TEC_NCO_LSB = 16;
  localparam int TEC_REF_LSB = 0;
endpackage

// File: rtl/tec_down_counter.sv
module tec_down_counter #(
  parameter int W = 12,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic at_zero;
  assign at_zero = (cnt == '0);
  assign wrap    = tick && !load && at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= RST_VAL;
    else if (load)    cnt <= load_val;
    else if (tick)    cnt <= at_zero ? period : cnt - 1'b1;
  end
endmodule

// File: rtl/tec_err_calc.sv
module tec_err_calc #(
  parameter int DIV_W = 12,
  parameter int ERR_W = 16
) (
  input  logic [DIV_W-1:0] count,
  input  logic [DIV_W-1:0] divide,
  output logic [ERR_W-1:0] err
);
  localparam int DW = DIV_W + 1;
  logic [DW-1:0] cnt_ext;
  logic [DW-1:0] half_ext;
  logic [DW-1:0] diff;

  assign cnt_ext  = {1'b0, count};
  assign half_ext = {2'b00, divide[DIV_W-1:1]};
  assign diff     = cnt_ext - half_ext;
  assign err      = {{(ERR_W-DW){diff[DW-1]}}, diff};
endmodule

// File: rtl/tec_out_reg.sv
module tec_out_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic [W-1:0] data,
  output logic         valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else if (load) begin
      data  <= load_data;
      valid <= 1'b1;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/timing_err_cmp.sv
module timing_err_cmp
  import tec_pkg::*;
#(
  parameter int DIV_W   = TEC_DIV_W,
  parameter int ERR_W   = TEC_ERR_W,
  parameter int CFG_W   = TEC_CFG_W,
  parameter int NCO_LSB = TEC_NCO_LSB,
  parameter int REF_LSB = TEC_REF_LSB,
  parameter logic [DIV_W-1:0] NCO_DIV_RST = 100,
  parameter logic [DIV_W-1:0] REF_DIV_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             nco_tick,
  input  logic             ref_tick,
  output logic [ERR_W-1:0] err_word,
  output logic             err_valid,
  input  logic             err_ready
);
  logic [DIV_W-1:0] nco_div, ref_div;
  logic [DIV_W-1:0] new_nco_div, new_ref_div;
  logic [DIV_W-1:0] nco_cnt, ref_cnt;
  logic             nco_wrap, ref_wrap;
  logic             capture;
  logic [ERR_W-1:0] err_next;

  assign new_nco_div = cfg_word[NCO_LSB +: DIV_W];
  assign new_ref_div = cfg_word[REF_LSB +: DIV_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nco_div <= NCO_DIV_RST;
      ref_div <= REF_DIV_RST;
    end else if (cfg_wr) begin
      nco_div <= new_nco_div;
      ref_div <= new_ref_div;
    end
  end

  tec_down_counter #(.W(DIV_W), .RST_VAL(NCO_DIV_RST)) u_nco_ctr (
    .clk(clk), .rst_n(rst_n), .load(cfg_wr), .load_val(new_nco_div),
    .period(nco_div), .tick(nco_tick), .cnt(nco_cnt), .wrap(nco_wrap)
  );

  tec_down_counter #(.W(DIV_W), .RST_VAL(REF_DIV_RST)) u_ref_ctr (
    .clk(clk), .rst_n(rst_n), .load(cfg_wr), .load_val(new_ref_div),
    .period(ref_div), .tick(ref_tick), .cnt(ref_cnt), .wrap(ref_wrap)
  );

  assign capture = ref_wrap;

  tec_err_calc #(.DIV_W(DIV_W), .ERR_W(ERR_W)) u_calc (
    .count(nco_cnt), .divide(nco_div), .err(err_next)
  );

  tec_out_reg #(.W(ERR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(capture), .load_data(err_next),
    .ready(err_ready), .data(err_word), .valid(err_valid)
  );

  logic unused_ok;
  assign unused_ok = nco_wrap;
endmodule

// File: rtl/timing_err_cmp_chk.sv
module timing_err_cmp_chk #(
  parameter int DIV_W   = 12,
  parameter int ERR_W   = 16,
  parameter int CFG_W   = 32,
  parameter int NCO_LSB = 16,
  parameter int REF_LSB = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [CFG_W-1:0] cfg_word,
  input logic             nco_tick,
  input logic             ref_tick,
  input logic [DIV_W-1:0] nco_cnt,
  input logic [DIV_W-1:0] ref_cnt,
  input logic             capture,
  input logic [ERR_W-1:0] err_word,
  input logic             err_valid,
  input logic             err_ready
);
  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(err_word));
  // R5
  cap_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> err_valid);
  // R9
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_ready) |=> err_valid);
  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (nco_cnt == $past(cfg_word[NCO_LSB +: DIV_W]))
            && (ref_cnt == $past(cfg_word[REF_LSB +: DIV_W])));
  // R7
  no_cap_on_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> !capture);
  // R2
  nco_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nco_tick && !cfg_wr && nco_cnt != '0) |=> nco_cnt == DIV_W'($past(nco_cnt) - 1'b1));
  // R3
  ref_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !cfg_wr && ref_cnt != '0) |=> ref_cnt == DIV_W'($past(ref_cnt) - 1'b1));
endmodule

bind timing_err_cmp timing_err_cmp_chk #(
  .DIV_W(DIV_W), .ERR_W(ERR_W), .CFG_W(CFG_W), .NCO_LSB(NCO_LSB), .REF_LSB(REF_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
  .nco_tick(nco_tick), .ref_tick(ref_tick), .nco_cnt(nco_cnt), .ref_cnt(ref_cnt),
  .capture(capture), .err_word(err_word), .err_valid(err_valid), .err_ready(err_ready)
);

// File: tb/sim_timing_err_cmp.sv
module sim_timing_err_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        nco_tick = 1'b0;
  logic        ref_tick = 1'b0;
  logic        err_ready = 1'b0;
  logic [15:0] err_word;
  logic        err_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  int m_nd = 100, m_rd = 3, m_nc = 100, m_rc = 3;
  logic [15:0] m_w = '0;
  logic        m_v = 1'b0;

  always #4 clk = ~clk;

  timing_err_cmp #(.NCO_DIV_RST(12'd100), .REF_DIV_RST(12'd3)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .nco_tick(nco_tick), .ref_tick(ref_tick), .err_word(err_word),
    .err_valid(err_valid), .err_ready(err_ready)
  );

  function automatic logic [15:0] exp_err(int cnt, int div);
    int d;
    d = cnt - div / 2;
    return d[15:0];
  endfunction

  task automatic chk_out(input string tag);
    total++;
    if (err_valid !== m_v || err_word !== m_w) begin
      bad++;
      $display("FAIL %s: valid=%0b word=%h expected valid=%0b word=%h",
               tag, err_valid, err_word, m_v, m_w);
    end
  endtask

  task automatic chk_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic nt, input logic rt, input logic cw,
                      input logic [31:0] w, input logic rdy, input string tag);
    bit cap;
    nco_tick = nt; ref_tick = rt; cfg_wr = cw; cfg_word = w; err_ready = rdy;
    @(posedge clk);
    if (cw) begin
      m_nd = int'(w[27:16]); m_rd = int'(w[11:0]);
      m_nc = m_nd; m_rc = m_rd;
      cap = 0;
    end else begin
      cap = rt && (m_rc == 0);
      if (cap) m_w = exp_err(m_nc, m_nd);
      if (nt) m_nc = (m_nc == 0) ? m_nd : m_nc - 1;
      if (rt) m_rc = (m_rc == 0) ? m_rd : m_rc - 1;
    end
    if (cap) m_v = 1'b1;
    else if (rdy) m_v = 1'b0;
    @(negedge clk);
    nco_tick = 0; ref_tick = 0; cfg_wr = 0;
    chk_out(tag);
  endtask

  function automatic logic [31:0] mk_cfg(int nd, int rd, logic [7:0] junk);
    return {junk[3:0], nd[11:0], junk[7:4], rd[11:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_val("R1 word", err_word, 16'h0);
    chk_val("R1 valid", {15'b0, err_valid}, 16'h0);
    // R1 reset preloads: ref 3 -> wraps on 4th tick, nco still 100
    for (int i = 0; i < 4; i++) step(0, 1, 0, '0, 0, "R1");
    chk_val("R1 default capture", err_word, 16'd50);
    step(0, 0, 0, '0, 1, "R9 drain");
    // R4 + R7: fields with junk around, ticks during cfg ignored
    step(1, 1, 1, 32'hF014_F000, 1, "R7 cfg cycle");
    chk_val("R7 no capture", {15'b0, err_valid}, 16'h0);
    step(0, 1, 0, '0, 1, "R4");
    chk_val("R4 field decode", err_word, 16'd10);
    // R2 count down
    for (int i = 0; i < 5; i++) step(1, 0, 0, '0, 1, "R2");
    step(0, 1, 0, '0, 1, "R2");
    chk_val("R2 after 5 ticks", err_word, 16'd5);
    for (int i = 0; i < 15; i++) step(1, 0, 0, '0, 1, "R2");
    step(0, 1, 0, '0, 1, "R5");
    chk_val("R5 negative error", err_word, 16'hFFF6);
    step(1, 0, 0, '0, 1, "R2 reload");
    step(0, 1, 0, '0, 1, "R2 reload");
    chk_val("R2 reload to divide", err_word, 16'd10);
    // R6 simultaneous
    step(1, 1, 0, '0, 1, "R6");
    chk_val("R6 pre-tick count", err_word, 16'd10);
    step(0, 1, 0, '0, 1, "R6");
    chk_val("R6 next wrap sees tick", err_word, 16'd9);
    // R9 back-pressure and overwrite
    step(0, 1, 0, '0, 0, "R9");
    step(0, 0, 0, '0, 0, "R9");
    chk_val("R9 valid held", {15'b0, err_valid}, 16'h1);
    step(1, 0, 0, '0, 0, "R9");
    step(0, 1, 0, '0, 0, "R9");
    chk_val("R9 overwrite", err_word, 16'd8);
    chk_val("R9 still valid", {15'b0, err_valid}, 16'h1);
    step(0, 0, 0, '0, 1, "R9");
    chk_val("R9 drained", {15'b0, err_valid}, 16'h0);
    // R3 reference period
    step(0, 0, 1, mk_cfg(9, 2, 8'h00), 1, "R3 cfg");
    step(0, 1, 0, '0, 1, "R3");
    step(0, 1, 0, '0, 1, "R3");
    chk_val("R3 no early wrap", {15'b0, err_valid}, 16'h0);
    step(0, 1, 0, '0, 1, "R3");
    chk_val("R3 wrap capture", err_word, 16'd5);
    // R8 hold
    for (int i = 0; i < 6; i++) step(1, 0, 0, '0, i[0], "R8");
    chk_val("R8 held", err_word, 16'd5);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic cw;
      logic [31:0] w;
      cw = ($urandom % 150) == 0;
      w = '0;
      if (cw) begin
        int nd;
        nd = ($urandom % 8 == 0) ? 4095 - int'($urandom % 4) : int'($urandom % 64);
        w = mk_cfg(nd, int'($urandom % 8), 8'($urandom));
      end
      step(1'($urandom % 3 != 0), 1'($urandom % 2), cw, w, 1'($urandom % 2),
           "R2 R3 R5 R6 R9 random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule